// File: doc/BRIEF.md
# Priority-coded programmable clock divider

This block turns a fast system clock into a square wave whose frequency is picked by an 8-bit control code. Only the most significant set bit of the code matters. It selects a half-period from a fixed, evenly stepped table of 4 to 11 system clocks. A code of all zeros selects the fastest setting, in which the output flips on every clock. A counter advances on each enabled clock edge. When it reaches the terminal count for the selected half-period, the output inverts and the counter starts again from zero.

The control code is registered every cycle, and the terminal count is worked out again from that register on every edge. A new code therefore takes effect while the divider runs, with no restart. If the counter is already past the new terminal count, it wraps and flips the output on the next enabled edge instead of running on. An enable input freezes the divider. A separate small divider gives a fixed slow square wave that flips every four clocks, and the remaining output bits are tied low.

Top module: `prio_clk_div`

## Requirements
- R1: The code input is captured into a register on every clock edge, during reset as well. The terminal count used at an edge comes from the code captured at the previous edge.
- R2: If the highest set bit of the captured code is bit i (bit 0 is the least significant), the half-period is 4 + i clocks and the terminal count is 3 + i. Set bits below the highest one have no effect.
- R3: An all-zero captured code gives a half-period of 1 clock: osc_o inverts on every enabled edge.
- R4: At an enabled edge where the counter is below the terminal count, the counter increments and osc_o holds. At an enabled edge where the counter equals the terminal count, osc_o inverts and the counter returns to 0. With a steady code, the first inversion after reset release comes on the half-period-th clock edge.
- R5: If a code change leaves the counter above the new terminal count, the next enabled edge sets the counter to 0 and inverts osc_o. The counter never exceeds the largest terminal count, 10.
- R6: While en is low, the counter and osc_o keep their values. The code register keeps capturing.
- R7: aux_o ignores en. It inverts on every fourth clock edge after reset release, so after k released edges it equals bit 0 of floor(k/4).
- R8: A synchronous active-high reset clears the counter, osc_o, the aux divider count and aux_o to zero.
- R9: pad_o is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Divider enable; low freezes the counter and osc_o |
| code | input | 8 | Frequency code; its highest set bit picks the half-period |
| osc_o | output | 1 | Divided square wave |
| aux_o | output | 1 | Fixed slow square wave that inverts every four clocks |
| pad_o | output | 6 | Unused output bits, held at zero |

## Verification
The bench sweeps all 256 codes. For each code it measures the first inversion after reset and the next three intervals, so a wrong priority order, an off-by-one terminal count or a wrong all-zero period shows up as a wrong interval. Two further tests change the code while the divider runs. Shortening the period with the counter above the new limit must give an inversion two edges after the change. A design that compared with equality would run away for a full counter wrap, and one without the code register would flip an edge early. Lengthening the period must stretch the current half-period to the new length. Enable is dropped with osc_o both low and high, and the bench checks that the remaining count resumes exactly. A design that kept counting, or that let the aux divider stop, would show a shifted inversion.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int CODE_W = 8;
    localparam int IDX_W  = $clog2(CODE_W);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } top_bit_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_WRAP = 2'd2
    } cnt_act_e;

    function automatic top_bit_t find_top_bit(code_t c);
        top_bit_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (c[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic int half_of(top_bit_t t, int base, int step, int zero_half);
        return t.hit ? (base + int'(t.idx) * step) : zero_half;
    endfunction

endpackage

// File: rtl/pcd_code_sel.sv
module pcd_code_sel
    import pcd_pkg::*;
#(
    parameter int BASE_HALF = 4,
    parameter int HALF_STEP = 1,
    parameter int ZERO_HALF = 1,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  code_t            code,
    output logic [CNT_W-1:0] term
);

    localparam int TOP_TERM = BASE_HALF + (CODE_W - 1) * HALF_STEP - 1;

    code_t    code_q;
    top_bit_t sel;

    // captured every edge, reset included, so the first released edge already sees a valid code
    always_ff @(posedge clk) begin
        code_q <= code;
    end

    always_comb begin
        sel  = find_top_bit(code_q);
        term = CNT_W'(half_of(sel, BASE_HALF, HALF_STEP, ZERO_HALF) - 1);
    end

    a_r1_code_captured: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (code_q == $past(code)));

    a_r3_zero_code_fastest: assert property (@(posedge clk) disable iff (rst)
        (code_q == '0) |-> (term == CNT_W'(ZERO_HALF - 1)));

    a_r2_msb_slowest: assert property (@(posedge clk) disable iff (rst)
        code_q[CODE_W-1] |-> (term == CNT_W'(TOP_TERM)));

endmodule

// File: rtl/pcd_half_counter.sv
module pcd_half_counter
    import pcd_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int MAX_TERM = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] term,
    output logic             osc
);

    logic [CNT_W-1:0] cnt;
    cnt_act_e         act;

    // greater-or-equal so a shortened period never lets the count run past its limit
    always_comb begin
        if (!en)               act = ACT_HOLD;
        else if (cnt >= term)  act = ACT_WRAP;
        else                   act = ACT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            osc <= 1'b0;
        end else begin
            case (act)
                ACT_STEP: cnt <= cnt + 1'b1;
                ACT_WRAP: begin
                    cnt <= '0;
                    osc <= ~osc;
                end
                default: ;
            endcase
        end
    end

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !osc));

    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt) && $stable(osc)));

    a_r4_step_below_term: assert property (@(posedge clk) disable iff (rst)
        (en && cnt < term) |=> (cnt == $past(cnt) + 1'b1 && $stable(osc)));

    a_r4_flip_at_term: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == term) |=> (cnt == '0 && osc != $past(osc)));

    a_r5_overrun_wraps: assert property (@(posedge clk) disable iff (rst)
        (en && cnt > term) |=> (cnt == '0 && osc != $past(osc)));

    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_TERM));

endmodule

// File: rtl/pcd_aux_div.sv
module pcd_aux_div #(
    parameter int AUX_DIV = 4,
    parameter int AUX_W   = 4
) (
    input  logic clk,
    input  logic rst,
    output logic aux
);

    localparam logic [AUX_W-1:0] AUX_LAST = AUX_W'(AUX_DIV - 1);

    logic [AUX_W-1:0] acnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acnt <= '0;
            aux  <= 1'b0;
        end else if (acnt == AUX_LAST) begin
            acnt <= '0;
            aux  <= ~aux;
        end else begin
            acnt <= acnt + 1'b1;
        end
    end

    a_r7_aux_quiet: assert property (@(posedge clk) disable iff (rst)
        (acnt != AUX_LAST) |=> $stable(aux));

    a_r7_aux_flip: assert property (@(posedge clk) disable iff (rst)
        (acnt == AUX_LAST) |=> (acnt == '0 && aux != $past(aux)));

    a_r8_aux_reset: assert property (@(posedge clk)
        rst |=> (acnt == '0 && !aux));

endmodule

// File: rtl/prio_clk_div.sv
module prio_clk_div
    import pcd_pkg::*;
#(
    parameter int BASE_HALF = 4,
    parameter int HALF_STEP = 1,
    parameter int ZERO_HALF = 1,
    parameter int AUX_DIV   = 4,
    parameter int AUX_W     = 4,
    parameter int PAD_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CODE_W-1:0] code,
    output logic             osc_o,
    output logic             aux_o,
    output logic [PAD_W-1:0] pad_o
);

    localparam int TOP_HALF = BASE_HALF + (CODE_W - 1) * HALF_STEP;
    localparam int MAX_HALF = (TOP_HALF > ZERO_HALF) ? TOP_HALF : ZERO_HALF;
    localparam int MAX_TERM = MAX_HALF - 1;
    localparam int CNT_W    = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF);

    logic [CNT_W-1:0] term;

    pcd_code_sel #(
        .BASE_HALF (BASE_HALF),
        .HALF_STEP (HALF_STEP),
        .ZERO_HALF (ZERO_HALF),
        .CNT_W     (CNT_W)
    ) u_sel (
        .clk  (clk),
        .rst  (rst),
        .code (code),
        .term (term)
    );

    pcd_half_counter #(
        .CNT_W    (CNT_W),
        .MAX_TERM (MAX_TERM)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .term (term),
        .osc  (osc_o)
    );

    pcd_aux_div #(
        .AUX_DIV (AUX_DIV),
        .AUX_W   (AUX_W)
    ) u_aux (
        .clk (clk),
        .rst (rst),
        .aux (aux_o)
    );

    assign pad_o = '0;

endmodule

// File: tb/sim_prio_clk_div.sv
module sim_prio_clk_div;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] code = 8'h00;
    logic       osc;
    logic       aux;
    logic [5:0] pad;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    prio_clk_div u0 (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .code  (code),
        .osc_o (osc),
        .aux_o (aux),
        .pad_o (pad)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic int exp_half(logic [7:0] c);
        int h = 1;
        for (int i = 0; i < 8; i++) if (c[i]) h = 4 + i;
        return h;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic [7:0] c);
        rst  = 1'b1;
        en   = 1'b1;
        code = c;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic wait_flip(output int n);
        logic p;
        p = osc;
        n = 0;
        do begin
            tick();
            n++;
        end while (osc == p && n < 64);
    endtask

    initial begin
        int n;
        int h;

        // full code sweep: R2, R3, R4, R8, R9
        for (int c = 0; c < 256; c++) begin
            do_reset(8'(c));
            h = exp_half(8'(c));
            chk(osc == 1'b0, "R8", "osc after reset", int'(osc), 0);
            chk(aux == 1'b0, "R8", "aux after reset", int'(aux), 0);
            wait_flip(n);
            chk(n == h, "R4", $sformatf("first flip code=%02h", c), n, h);
            for (int k = 0; k < 3; k++) begin
                wait_flip(n);
                chk(n == h, (c == 0) ? "R3" : "R2",
                    $sformatf("half-period code=%02h", c), n, h);
            end
            chk(pad == 6'd0, "R9", "pad bits", int'(pad), 0);
        end

        // shorten on the fly with counter above new limit: R5, R1
        do_reset(8'h80);
        repeat (9) tick();
        code = 8'h01;
        wait_flip(n);
        chk(n == 2, "R5", "overrun wrap after shortening", n, 2);
        wait_flip(n);
        chk(n == 4, "R1", "period after shortening", n, 4);

        // lengthen on the fly mid half-period: R1
        do_reset(8'h01);
        wait_flip(n);
        chk(n == 4, "R4", "first flip code=01", n, 4);
        tick();
        code = 8'h80;
        wait_flip(n);
        chk(n == 10, "R1", "flip after lengthening", n, 10);
        code = 8'h83;
        wait_flip(n);
        chk(n == 11, "R2", "lower bits ignored code=83", n, 11);

        // enable hold with osc low then high: R6
        do_reset(8'h04);
        repeat (3) tick();
        en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            tick();
            chk(osc == 1'b0, "R6", "osc held low", int'(osc), 0);
        end
        en = 1'b1;
        wait_flip(n);
        chk(n == 3, "R6", "resume from count 3", n, 3);
        repeat (2) tick();
        en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            chk(osc == 1'b1, "R6", "osc held high", int'(osc), 1);
        end
        en = 1'b1;
        wait_flip(n);
        chk(n == 4, "R6", "resume from count 2", n, 4);

        // aux divider ignores enable: R7
        do_reset(8'h10);
        for (int k = 1; k <= 48; k++) begin
            if (k == 6)  en = 1'b0;
            if (k == 30) en = 1'b1;
            tick();
            chk(aux == 1'(((k / 4) % 2)), "R7", $sformatf("aux after %0d edges", k),
                int'(aux), (k / 4) % 2);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule